// File: doc/BRIEF.md
# Set-clear-toggle register alias bank

This block is a bank of control registers. Software can change single bits of any register in one bus write, with no read-modify-write. Each register takes a 16-byte window, which is four word addresses. Word 0 of the window takes a plain store. Words 1, 2 and 3 are the set, clear and toggle aliases: the write data is used as a bit mask and is ORed in, cleared out or inverted. Reads return the stored value, whichever of the four words is addressed. Every register also has a hardware load port. A bus write to the same register in the same cycle takes priority over that port.

One register holds a chip-reset request bit. A bus write that leaves this bit at 1 produces a one-cycle pulse on `rst_req`. The bit itself is never stored, so software cannot read it back as 1.

Every access is accepted in the cycle it is presented, so there is no back-pressure. `wr_en` and `rd_en` act as valid strobes with an implied ready that is always high. A read returns its data one cycle later. An access outside the bank is also answered one cycle later: read data is zero and `err` pulses high for one cycle.

Top module: `stc_bank`

## Requirements
- R1: After reset all registers hold zero, and `rd_data`, `err` and `rst_req` are low.
- R2: A write with address bits [3:2] = 0 replaces the addressed register with `wr_data`.
- R3: A write with address bits [3:2] = 1 ORs `wr_data` into the addressed register.
- R4: A write with address bits [3:2] = 2 clears every register bit whose `wr_data` bit is 1.
- R5: A write with address bits [3:2] = 3 inverts every register bit whose `wr_data` bit is 1.
- R6: A read at any of the four words of a register returns that register's value in the next cycle. In any cycle that follows no in-range read, `rd_data` is zero.
- R7: The bank spans addresses 0x00 to 0x7F, and address bits [6:4] select the register. An access at 0x80 or above makes `err` high for exactly the next cycle, reads as zero, and changes no register.
- R8: The reset bit is bit 1 of register 1. Any bus write that would leave this bit at 1 makes `rst_req` high for exactly the next cycle. The stored bit always reads as 0.
- R9: If `hw_we[i]` is high, register i loads slice i of `hw_data`. A bus write to the same register in the same cycle wins. Hardware loads never raise `rst_req`.
- R10: Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, or bit mask for an alias |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after the read |
| err | output | 1 | Out-of-range access flag, one cycle after the access |
| hw_we | input | 8 | Per-register hardware load enable |
| hw_data | input | 256 | Hardware load values, register i in bits [32i+31:32i] |
| reg_q | output | 256 | Current register values, register i in bits [32i+31:32i] |
| rst_req | output | 1 | One-cycle chip-reset request |

## Verification
On every cycle the assertions check four things:
- the timing and exclusivity of the error flag;
- that read data is zero when no in-range read came before;
- that the reset bit is never stored and only pulses after a write;
- the result of plain, set and clear writes in the register the write addressed.

Only the bench's scenarios can show three further points. The first is the exact result of toggles and of reads through every alias. The second is that a bus write wins over a hardware load on the same register while a load on a neighbouring register still lands. The third is that out-of-range writes leave every register untouched.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } alias_op_t;

  localparam int WIN_LSB = 4;  // each register owns a 16-byte window
endpackage

// File: rtl/stc_decode.sv
module stc_decode
  import stc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NREG = 8,
  parameter int IW   = 3
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output alias_op_t     op
);
  localparam int SPAN = NREG << WIN_LSB;

  logic lo_unused;
  assign lo_unused = ^addr[1:0];

  assign hit = ({{(32-AW){1'b0}}, addr} < 32'(SPAN));
  assign idx = addr[WIN_LSB +: IW];
  assign op  = alias_op_t'(addr[3:2]);
endmodule

// File: rtl/stc_cell.sv
module stc_cell
  import stc_pkg::*;
#(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] SC_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  alias_op_t     op,
  input  logic [DW-1:0] wdata,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_data,
  output logic [DW-1:0] q,
  output logic          fire
);
  logic [DW-1:0] bus_nxt;
  logic [DW-1:0] d;

  always_comb begin
    unique case (op)
      OP_STORE: bus_nxt = wdata;
      OP_SET:   bus_nxt = q | wdata;
      OP_CLR:   bus_nxt = q & ~wdata;
      default:  bus_nxt = q ^ wdata;
    endcase
  end

  always_comb begin
    if (bus_we)     d = bus_nxt;
    else if (hw_we) d = hw_data;
    else            d = q;
  end

  assign fire = bus_we && (|(bus_nxt & SC_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d & ~SC_MASK;
  end
endmodule

// File: rtl/stc_bank.sv
module stc_bank
  import stc_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int RST_REG = 1,
  parameter int RST_BIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data,
  output logic               err,
  input  logic [NREG-1:0]    hw_we,
  input  logic [NREG*DW-1:0] hw_data,
  output logic [NREG*DW-1:0] reg_q,
  output logic               rst_req
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          hit;
  logic [IW-1:0] idx;
  alias_op_t     op;
  logic [DW-1:0] q_arr [NREG];
  logic [NREG-1:0] fire_vec;

  stc_decode #(.AW(AW), .NREG(NREG), .IW(IW)) u_dec (
    .addr(addr), .hit(hit), .idx(idx), .op(op)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] SCM = (i == RST_REG) ? (DW'(1) << RST_BIT) : '0;
    logic bus_we_i;
    assign bus_we_i = wr_en && hit && (idx == IW'(i));

    stc_cell #(.DW(DW), .SC_MASK(SCM)) u_cell (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we_i), .op(op), .wdata(wr_data),
      .hw_we(hw_we[i]), .hw_data(hw_data[i*DW +: DW]),
      .q(q_arr[i]), .fire(fire_vec[i])
    );
    assign reg_q[i*DW +: DW] = q_arr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      err     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rd_data <= (rd_en && hit) ? q_arr[idx] : '0;
      err     <= (rd_en || wr_en) && !hit;
      rst_req <= |fire_vec;
    end
  end
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int RST_REG = 1,
  parameter int RST_BIT = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic               wr_en,
  input logic [DW-1:0]      wr_data,
  input logic               rd_en,
  input logic [DW-1:0]      rd_data,
  input logic               err,
  input logic [NREG*DW-1:0] reg_q,
  input logic               rst_req
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << RST_BIT);

  logic in_bank, lo_unused;
  logic pv_store, pv_set, pv_clr;
  logic [IW-1:0] pv_idx;
  logic [DW-1:0] pv_w, cur;

  assign lo_unused = ^addr[1:0];
  assign in_bank = ({{(32-AW){1'b0}}, addr} < 32'(NREG * 16));
  assign cur = reg_q[pv_idx*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_store <= 1'b0; pv_set <= 1'b0; pv_clr <= 1'b0;
      pv_idx <= '0; pv_w <= '0;
    end else begin
      pv_store <= wr_en && in_bank && (addr[3:2] == 2'd0);
      pv_set   <= wr_en && in_bank && (addr[3:2] == 2'd1);
      pv_clr   <= wr_en && in_bank && (addr[3:2] == 2'd2);
      pv_idx   <= addr[4 +: IW];
      pv_w     <= wr_data;
    end
  end

  assert_err_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !in_bank) |=> err);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en || rd_en) && !in_bank) |=> !err);
  assert_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && in_bank) |=> (rd_data == '0));
  assert_rst_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_en));
  assert_rst_bit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[RST_REG*DW + RST_BIT]);
  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pv_store |-> ((cur & KEEP) == (pv_w & KEEP)));
  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pv_set |-> ((cur & pv_w & KEEP) == (pv_w & KEEP)));
  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pv_clr |-> ((cur & pv_w) == '0));
endmodule

bind stc_bank stc_checker #(
  .AW(AW), .DW(DW), .NREG(NREG), .RST_REG(RST_REG), .RST_BIT(RST_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .err(err), .reg_q(reg_q), .rst_req(rst_req)
);

// File: tb/test_stc_bank.sv
module test_stc_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic err, rst_req;
  logic [NREG-1:0] hw_we = '0;
  logic [NREG*DW-1:0] hw_data = '0;
  logic [NREG*DW-1:0] reg_q;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  stc_bank i_stc_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .err(err), .hw_we(hw_we),
    .hw_data(hw_data), .reg_q(reg_q), .rst_req(rst_req)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] apply(int op, logic [DW-1:0] old, logic [DW-1:0] w);
    case (op)
      0: return w;
      1: return old | w;
      2: return old & ~w;
      default: return old ^ w;
    endcase
  endfunction

  task automatic do_wr(logic [7:0] a, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [7:0] a, logic [DW-1:0] exp, string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
    chk({req, " err"}, DW'(err), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rd_data", rd_data, '0);
    chk("R1 err", DW'(err), '0);
    chk("R1 rst_req", DW'(rst_req), '0);
    for (int i = 0; i < NREG; i++) do_rd(8'(i*16), '0, "R1 reg");

    // R2..R5, R6, R8, R10: sweep every register, alias and pattern
    for (int i = 0; i < NREG; i++)
      for (int op = 0; op < 4; op++)
        for (int p = 0; p < 3; p++) begin
          logic [DW-1:0] d, nv;
          logic fire;
          d = 32'h9E37_79B9 * DW'(i*16 + op*4 + p + 1);
          d = d ^ (32'hFFFF_0000 >> (p*8));
          if (p == 2) d = d | 32'h2;
          nv = apply(op, mdl[i], d);
          fire = (i == 1) && nv[1];
          mdl[i] = (i == 1) ? (nv & ~32'h2) : nv;
          do_wr(8'(i*16 + op*4 + p), d);   // R10: low bits junk
          chk("R8 rst_req pulse", DW'(rst_req), DW'(fire));
          @(negedge clk);
          chk("R8 rst_req one cycle", DW'(rst_req), '0);
          case (op)
            0: do_rd(8'(i*16 + ((op+1)%4)*4 + (3-p)), mdl[i], "R2 store R6");
            1: do_rd(8'(i*16 + ((op+1)%4)*4 + (3-p)), mdl[i], "R3 set R6");
            2: do_rd(8'(i*16 + ((op+1)%4)*4 + (3-p)), mdl[i], "R4 clear R6");
            default: do_rd(8'(i*16 + ((op+1)%4)*4 + (3-p)), mdl[i], "R5 toggle R6");
          endcase
        end

    // R6: no read -> rd_data zero
    @(negedge clk);
    chk("R6 idle rd_data", rd_data, '0);

    // R9: hardware load alone
    @(negedge clk);
    hw_we = 8'h08; hw_data[3*DW +: DW] = 32'hA5A5_0F0F;
    @(negedge clk);
    hw_we = '0;
    mdl[3] = 32'hA5A5_0F0F;
    do_rd(8'h30, mdl[3], "R9 hw load");
    // R9: bus wins on reg 3, hw lands on reg 4 in the same cycle
    @(negedge clk);
    hw_we = 8'h18;
    hw_data[3*DW +: DW] = 32'h1111_1111;
    hw_data[4*DW +: DW] = 32'h4444_CCCC;
    addr = 8'h30; wr_data = 32'hDEAD_BEEF; wr_en = 1'b1;
    @(negedge clk);
    hw_we = '0; wr_en = 1'b0;
    mdl[3] = 32'hDEAD_BEEF; mdl[4] = 32'h4444_CCCC;
    do_rd(8'h3C, mdl[3], "R9 bus wins");
    do_rd(8'h44, mdl[4], "R9 neighbour hw load");
    // R9/R8: hw load of reg 1 does not store or fire the reset bit
    @(negedge clk);
    hw_we = 8'h02; hw_data[1*DW +: DW] = 32'hFFFF_FFFF;
    @(negedge clk);
    hw_we = '0;
    chk("R9 hw no rst_req", DW'(rst_req), '0);
    mdl[1] = 32'hFFFF_FFFD;
    do_rd(8'h10, mdl[1], "R8 hw load masks reset bit");

    // R7: out-of-range reads
    for (int a = 8'h80; a < 256; a += 4) begin
      @(negedge clk);
      addr = 8'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R7 oor rd_data", rd_data, '0);
      chk("R7 oor err", DW'(err), 32'd1);
      @(negedge clk);
      chk("R7 err one cycle", DW'(err), '0);
    end
    // R7: out-of-range writes change nothing
    for (int a = 8'h80; a < 256; a += 16) begin
      do_wr(8'(a), 32'hFFFF_FFFF);
      chk("R7 oor write err", DW'(err), 32'd1);
      chk("R7 oor write no rst_req", DW'(rst_req), '0);
    end
    for (int i = 0; i < NREG; i++) do_rd(8'(i*16 + 8), mdl[i], "R7 regs untouched");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule